// File: doc/BRIEF.md
# Frame Interrupt Timer with Test Data Port

This block sits on a processor's external memory bus as a small test peripheral. It holds a few 16-bit registers that software reads and writes over a simple synchronous register bus. Two of them only store words for a digital I/O port outside this block. The other two set a frame interrupt schedule: a one-cycle pulse comes a programmable number of clocks after reset, and then at a fixed programmable interval. A live countdown shows how many clocks remain until the next pulse.

A 32-bit test data word is also readable. Its low half is a clock counter that runs freely. Its high half counts how many times the word has been read. Software can use it to check the bus path and to measure elapsed time between reads.

Top module: `frame_irq_timer`

## Requirements
- R1: After reset the stored values are: I/O data 0x0001, I/O control 0x3000, start count 0x0100, period count 0x0100. Also after reset, `irq` is low, `bus_rdata` is zero, and both test word counters are zero.
- R2: Word address decode on `bus_addr[3:0]`. Bit 3 picks the group and bit 2 must be zero. Group 0: 0x0 is I/O data and 0x1 is I/O control. Group 1: 0x8 is the test word, 0x9 is the start count, 0xA is the period count and 0xB is the countdown. A read of a 16-bit register returns its value in bits 15:0, with bits 31:16 zero. The I/O data and I/O control values are also driven on `dio_data` and `dio_ctrl`.
- R3: Counting edges from reset release, the first `irq` pulse appears after edge S, where S is the start count. A start count of 0 behaves as 1.
- R4: After each pulse, the next pulse comes P edges later, where P is the period count and 0 behaves as 1. When P is at least 2, each pulse lasts one cycle.
- R5: A write to the start count restarts the schedule. No pulse appears on the write edge, and the next pulse comes S edges after it.
- R6: A write to the period count does not change the interval already running. The new value applies from the next reload.
- R7: When the programmed counts are 1 or more, reading the countdown returns the number of edges left until the edge that raises the next pulse. Writes to the countdown are ignored.
- R8: Bits 15:0 of the test word hold the number of clock edges since reset release that came before the read's capture edge, modulo 2^16.
- R9: Bits 31:16 of the test word hold the number of earlier test word reads, modulo 2^16, so the first read shows 0. Writes to the test word address are ignored and do not change this count.
- R10: Addresses that are not mapped read as zero, and writes to them change no register.
- R11: `bus_rdata` is updated on the clock edge where a read is presented, and it holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_en | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | REG_W (16) | Write data |
| bus_rdata | output | 2*REG_W (32) | Read data, valid the cycle after the access |
| irq | output | 1 | Frame interrupt pulse |
| dio_data | output | REG_W (16) | Stored I/O data word |
| dio_ctrl | output | REG_W (16) | Stored I/O control word |

## Verification
The assertions assume that inputs change only between clock edges and that `bus_we` has a meaning only while `bus_en` is high. They also assume that no register has a value other than the one set by reset or by a bus write. The bench drives every input one time unit after the rising edge and samples outputs on the falling edge. It never presents a read and a write in the same cycle. It does not read the countdown while a programmed count is zero, because the zero-as-one rule would make the pending count differ from the stored count.

// File: rtl/frame_timer_pkg.sv
`timescale 1ns/1ps
package frame_timer_pkg;

    // Low offset field, meaning depends on the group bit
    localparam logic [1:0] OFS_DIO_DATA = 2'd0;
    localparam logic [1:0] OFS_DIO_CTRL = 2'd1;
    localparam logic [1:0] OFS_TEST     = 2'd0;
    localparam logic [1:0] OFS_START    = 2'd1;
    localparam logic [1:0] OFS_PERIOD   = 2'd2;
    localparam logic [1:0] OFS_DOWN     = 2'd3;

    // One-hot register select
    typedef struct packed {
        logic dio_data;
        logic dio_ctrl;
        logic test_word;
        logic start;
        logic period;
        logic down;
    } reg_sel_t;

endpackage

// File: rtl/ft_addr_decode.sv
`timescale 1ns/1ps
module ft_addr_decode
    import frame_timer_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel,
    output logic              hit
);
    localparam int GRP_BIT = ADDR_W - 1;

    logic       pad_ok;
    logic       grp;
    logic [1:0] ofs;

    assign pad_ok = ~|addr[ADDR_W-2:2];
    assign grp    = addr[GRP_BIT];
    assign ofs    = addr[1:0];

    always_comb begin
        sel = '0;
        if (en && pad_ok) begin
            if (!grp) begin
                sel.dio_data  = (ofs == OFS_DIO_DATA);
                sel.dio_ctrl  = (ofs == OFS_DIO_CTRL);
            end else begin
                sel.test_word = (ofs == OFS_TEST);
                sel.start     = (ofs == OFS_START);
                sel.period    = (ofs == OFS_PERIOD);
                sel.down      = (ofs == OFS_DOWN);
            end
        end
    end

    assign hit = |sel;

    // R2: at most one register is selected
    always_comb begin
        a_r2_onehot_sel: assert ($onehot0(sel));
    end

endmodule

// File: rtl/ft_ctrl_regs.sv
`timescale 1ns/1ps
module ft_ctrl_regs
    import frame_timer_pkg::*;
#(
    parameter int               REG_W      = 16,
    parameter logic [REG_W-1:0] DIO_RST    = 16'h0001,
    parameter logic [REG_W-1:0] DIOC_RST   = 16'h3000,
    parameter logic [REG_W-1:0] START_RST  = 16'h0100,
    parameter logic [REG_W-1:0] PERIOD_RST = 16'h0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  reg_sel_t         sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] dio_data,
    output logic [REG_W-1:0] dio_ctrl,
    output logic [REG_W-1:0] start_cnt,
    output logic [REG_W-1:0] period_cnt,
    output logic             restart
);
    typedef struct packed {
        logic [REG_W-1:0] dio_data;
        logic [REG_W-1:0] dio_ctrl;
        logic [REG_W-1:0] start;
        logic [REG_W-1:0] period;
    } ctrl_t;

    ctrl_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            if (sel.dio_data) regs_d.dio_data = wdata;
            if (sel.dio_ctrl) regs_d.dio_ctrl = wdata;
            if (sel.start)    regs_d.start    = wdata;
            if (sel.period)   regs_d.period   = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.dio_data <= DIO_RST;
            regs_q.dio_ctrl <= DIOC_RST;
            regs_q.start    <= START_RST;
            regs_q.period   <= PERIOD_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dio_data   = regs_q.dio_data;
    assign dio_ctrl   = regs_q.dio_ctrl;
    assign start_cnt  = regs_q.start;
    assign period_cnt = regs_q.period;
    assign restart    = wr && sel.start;

    // R6: the period only changes through its own write
    a_r6_period_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && sel.period) |=> $stable(period_cnt));

    // R10: no stored value moves without a mapped write
    a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(regs_q));

endmodule

// File: rtl/ft_countdown.sv
`timescale 1ns/1ps
module ft_countdown #(
    parameter int               CNT_W     = 16,
    parameter logic [CNT_W-1:0] START_RST = 16'h0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] restart_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] remain,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } cd_t;

    cd_t cd_d, cd_q;

    always_comb begin
        cd_d     = cd_q;
        cd_d.irq = 1'b0;
        if (restart) begin
            cd_d.cnt = restart_val;
        end else if (cd_q.cnt <= ONE) begin
            cd_d.cnt = period;
            cd_d.irq = 1'b1;
        end else begin
            cd_d.cnt = cd_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd_q.cnt <= START_RST;
            cd_q.irq <= 1'b0;
        end else begin
            cd_q <= cd_d;
        end
    end

    assign remain = cd_q.cnt;
    assign irq    = cd_q.irq;

    // R3: a running count steps down by one with no pulse
    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && remain > ONE) |=> (remain == $past(remain) - ONE) && !irq);

    // R4: expiry raises the pulse and reloads from the period
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && remain <= ONE) |=> irq && (remain == $past(period)));

    // R5: a restart suppresses the pulse and loads the new start
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !irq && (remain == $past(restart_val)));

endmodule

// File: rtl/ft_test_word.sv
`timescale 1ns/1ps
module ft_test_word #(
    parameter int REG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    output logic [2*REG_W-1:0] word
);
    localparam logic [REG_W-1:0] INC = REG_W'(1);

    typedef struct packed {
        logic [REG_W-1:0] reads;
        logic [REG_W-1:0] ticks;
    } tw_t;

    tw_t tw_d, tw_q;

    always_comb begin
        tw_d       = tw_q;
        tw_d.ticks = tw_q.ticks + INC;
        if (take) tw_d.reads = tw_q.reads + INC;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tw_q <= '0;
        else        tw_q <= tw_d;
    end

    assign word = tw_q;

    // R8: the tick field advances on every edge, with wrap
    a_r8_tick: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> word[REG_W-1:0] == $past(word[REG_W-1:0]) + INC);

    // R9: the read field moves only on a test word read
    a_r9_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> word[2*REG_W-1:REG_W] == $past(word[2*REG_W-1:REG_W]) + INC);
    a_r9_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(word[2*REG_W-1:REG_W]));

endmodule

// File: rtl/frame_irq_timer.sv
`timescale 1ns/1ps
module frame_irq_timer
    import frame_timer_pkg::*;
#(
    parameter int               REG_W      = 16,
    parameter int               ADDR_W     = 4,
    parameter logic [REG_W-1:0] DIO_RST    = 16'h0001,
    parameter logic [REG_W-1:0] DIOC_RST   = 16'h3000,
    parameter logic [REG_W-1:0] START_RST  = 16'h0100,
    parameter logic [REG_W-1:0] PERIOD_RST = 16'h0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [2*REG_W-1:0] bus_rdata,
    output logic               irq,
    output logic [REG_W-1:0]   dio_data,
    output logic [REG_W-1:0]   dio_ctrl
);
    localparam int WORD_W = 2 * REG_W;

    reg_sel_t         sel;
    logic             hit;
    logic             rd, wr;
    logic [REG_W-1:0] start_cnt, period_cnt, remain;
    logic             restart;
    logic [WORD_W-1:0] test_word;

    assign rd = bus_en && !bus_we;
    assign wr = bus_en &&  bus_we;

    ft_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .en   (bus_en),
        .addr (bus_addr),
        .sel  (sel),
        .hit  (hit)
    );

    ft_ctrl_regs #(
        .REG_W      (REG_W),
        .DIO_RST    (DIO_RST),
        .DIOC_RST   (DIOC_RST),
        .START_RST  (START_RST),
        .PERIOD_RST (PERIOD_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr),
        .sel        (sel),
        .wdata      (bus_wdata),
        .dio_data   (dio_data),
        .dio_ctrl   (dio_ctrl),
        .start_cnt  (start_cnt),
        .period_cnt (period_cnt),
        .restart    (restart)
    );

    ft_countdown #(.CNT_W(REG_W), .START_RST(START_RST)) u_cd (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .restart_val (bus_wdata),
        .period      (period_cnt),
        .remain      (remain),
        .irq         (irq)
    );

    ft_test_word #(.REG_W(REG_W)) u_tw (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (rd && sel.test_word),
        .word  (test_word)
    );

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd) begin
            if (sel.dio_data)       rd_d.rdata = WORD_W'(dio_data);
            else if (sel.dio_ctrl)  rd_d.rdata = WORD_W'(dio_ctrl);
            else if (sel.test_word) rd_d.rdata = test_word;
            else if (sel.start)     rd_d.rdata = WORD_W'(start_cnt);
            else if (sel.period)    rd_d.rdata = WORD_W'(period_cnt);
            else if (sel.down)      rd_d.rdata = WORD_W'(remain);
            else                    rd_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    // R10: an unmapped read returns zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !hit) |=> bus_rdata == '0);

    // R11: read data holds when no read is presented
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata));

    // R2: a 16-bit register read leaves the upper half clear
    a_r2_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit && !sel.test_word) |=> bus_rdata[WORD_W-1:REG_W] == '0);

endmodule

// File: tb/tb_frame_irq_timer.sv
`timescale 1ns/1ps
module tb_frame_irq_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [15:0] dio_data, dio_ctrl;

    always #5 clk = ~clk;

    frame_irq_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .dio_data(dio_data), .dio_ctrl(dio_ctrl)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string phase   = "R3";

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: absolute edge times
    int          edge_no;
    int          next_fire;
    int          m_dio, m_dioc, m_start, m_period, m_reads;
    logic        exp_irq;
    logic [31:0] exp_rdata;
    string       rtag;

    function automatic int at_least_one(int v);
        return (v < 1) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            edge_no = 0; m_dio = 'h0001; m_dioc = 'h3000;
            m_start = 'h0100; m_period = 'h0100; m_reads = 0;
            next_fire = 'h0100; exp_irq = 0; exp_rdata = 0; rtag = "R11";
        end else begin
            edge_no++;
            if (bus_en && !bus_we) begin
                case (bus_addr)
                    4'h0: begin exp_rdata = 32'(m_dio);    rtag = "R2"; end
                    4'h1: begin exp_rdata = 32'(m_dioc);   rtag = "R2"; end
                    4'h8: begin
                        exp_rdata = {16'(m_reads), 16'(edge_no - 1)};
                        m_reads = (m_reads + 1) % 65536;
                        rtag = "R8 R9";
                    end
                    4'h9: begin exp_rdata = 32'(m_start);  rtag = "R2"; end
                    4'hA: begin exp_rdata = 32'(m_period); rtag = "R2"; end
                    4'hB: begin exp_rdata = 32'(next_fire - (edge_no - 1)); rtag = "R7"; end
                    default: begin exp_rdata = 0; rtag = "R10"; end
                endcase
            end else begin
                rtag = "R11";
            end
            if (bus_en && bus_we && bus_addr == 4'h9) begin
                exp_irq = 0;
                next_fire = edge_no + at_least_one(int'(bus_wdata));
            end else if (edge_no == next_fire) begin
                exp_irq = 1;
                next_fire = edge_no + at_least_one(m_period);
            end else begin
                exp_irq = 0;
            end
            if (bus_en && bus_we) begin
                case (bus_addr)
                    4'h0: m_dio    = int'(bus_wdata);
                    4'h1: m_dioc   = int'(bus_wdata);
                    4'h9: m_start  = int'(bus_wdata);
                    4'hA: m_period = int'(bus_wdata);
                    default: ;
                endcase
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(phase, {31'd0, irq}, {31'd0, exp_irq});
            check(rtag, bus_rdata, exp_rdata);
            check("R2", {dio_ctrl, dio_data}, {16'(m_dioc), 16'(m_dio)});
        end
    end

    task automatic bus_op(bit we, logic [3:0] a, logic [15:0] d);
        bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R11 actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: values held in reset
        check("R1", {31'd0, irq}, 32'd0);
        check("R1", bus_rdata, 32'd0);
        check("R1", {dio_ctrl, dio_data}, 32'h3000_0001);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R1 R2: readback of reset values and first test word
        for (int a = 0; a < 16; a++) bus_op(1'b0, 4'(a), 16'h0);

        phase = "R3";
        idle(300);
        phase = "R4";
        idle(600);

        phase = "R5";
        bus_op(1'b1, 4'h9, 16'd10);
        bus_op(1'b1, 4'hA, 16'd7);
        for (int k = 0; k < 6; k++) begin
            bus_op(1'b0, 4'hB, 16'h0);
            idle(3);
        end
        idle(30);

        phase = "R6";
        idle(3);
        bus_op(1'b1, 4'hA, 16'd3);
        bus_op(1'b0, 4'hB, 16'h0);
        idle(40);

        // R7: countdown is read-only
        phase = "R7";
        bus_op(1'b1, 4'hB, 16'hFFFF);
        bus_op(1'b0, 4'hB, 16'h0);
        bus_op(1'b0, 4'hB, 16'h0);

        // R2 and R10: data registers and stray writes
        bus_op(1'b1, 4'h0, 16'hA5C3);
        bus_op(1'b1, 4'h1, 16'h0F0F);
        bus_op(1'b1, 4'h4, 16'h1234);
        bus_op(1'b1, 4'h7, 16'h5678);
        bus_op(1'b1, 4'hC, 16'h9ABC);
        bus_op(1'b1, 4'hF, 16'hDEF0);
        bus_op(1'b1, 4'h2, 16'h1111);
        for (int a = 0; a < 16; a++) bus_op(1'b0, 4'(a), 16'h0);

        // R4 edge cases: period 1 and 0, start 0
        phase = "R4";
        bus_op(1'b1, 4'hA, 16'd1);
        idle(12);
        bus_op(1'b1, 4'hA, 16'd0);
        phase = "R5";
        bus_op(1'b1, 4'h9, 16'd0);
        idle(12);
        phase = "R4";
        bus_op(1'b1, 4'hA, 16'd5);
        bus_op(1'b1, 4'h9, 16'd4);
        idle(20);

        // R9: write to the test word is ignored
        bus_op(1'b1, 4'h8, 16'hFFFF);
        bus_op(1'b0, 4'h8, 16'h0);

        // R8 R9: back-to-back reads through both wraps
        for (int k = 0; k < 65540; k++) bus_op(1'b0, 4'h8, 16'h0);
        idle(10);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule